// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits in the receive path of an Ethernet MAC and decides, one frame at a time, whether a frame should be kept. It watches the six destination-address bytes as they arrive, one byte per strobe, and builds both the full 48-bit address and a running CRC-32 over those bytes. From these it judges the frame against a configured station address, a 64-bin multicast hash table and a set of mode bits. The modes are promiscuous, pass-all with status, pass-all-multicast, inverse unicast matching and broadcast rejection.

Once the sixth byte has been taken, the verdict and a small status word are registered. They stay on the outputs until the next frame begins. The MAC's frame logic uses the accept flag to keep or discard the rest of the frame. Software-facing logic can read the status word to learn why a frame passed, even when a permissive mode forced acceptance.

Top module: `eaf_rx_filter`

## Requirements
- R1: After a synchronous reset, `result_valid`, `accept` and every bit of `filt_status` read 0.
- R2: A byte is taken when `da_valid` is high. `da_start` together with `da_valid` begins a frame, and that byte is address byte 0. Byte k occupies address bits [8k+7:8k], and `cfg_station_addr` uses the same layout. The outputs update on the clock edge after the edge that takes the sixth byte. They then hold until a new frame start, which clears all three outputs at its edge. Valid bytes beyond the sixth, and valid bytes with no frame begun, change nothing.
- R3: For a unicast frame (group bit, bit 0 of byte 0, clear), the filter verdict is (address equals `cfg_station_addr`) XOR `cfg_inverse`.
- R4: For a group frame that is not broadcast, the filter verdict is `cfg_hash_table[idx]`. To form idx, a 32-bit register starts at all ones and takes the 48 address bits in order, bit 0 first. Each bit b does: f = reg[31]^b; reg = (reg<<1) ^ (f ? 32'h04C11DB7 : 0). idx is reg[31:26] at the end, with no final inversion.
- R5: With `cfg_pass_all_mcast` set, the verdict is 1 for every non-broadcast group frame.
- R6: For the all-ones broadcast address, the verdict is 1 unless `cfg_bcast_reject` is set, in which case it is 0.
- R7: With `cfg_promisc` set, `accept` is 1 for every frame, including a broadcast under `cfg_bcast_reject`.
- R8: With `cfg_pass_all` set, `accept` is 1 for every frame, while `filt_status[0]` still gives the verdict of R3 to R6.
- R9: `filt_status` bits are [0] verdict, [1] exact station match, [2] hash bin hit (group frames only, else 0), [3] group bit, [4] broadcast. `accept` equals verdict OR `cfg_promisc` OR `cfg_pass_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| da_start | input | 1 | Marks the first address byte of a frame |
| da_valid | input | 1 | Address byte strobe |
| da_byte | input | 8 | Address byte |
| cfg_station_addr | input | 48 | Exact-match station address, byte 0 in bits 7:0 |
| cfg_hash_table | input | 64 | Multicast hash bins |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_pass_all | input | 1 | Accept every frame, still report verdict |
| cfg_pass_all_mcast | input | 1 | Accept every non-broadcast group frame |
| cfg_inverse | input | 1 | Invert the unicast exact match |
| cfg_bcast_reject | input | 1 | Refuse broadcast frames |
| result_valid | output | 1 | Verdict and status are valid |
| accept | output | 1 | Keep the frame |
| filt_status | output | 5 | Match reasons, see R9 |

## Verification
The assertions rely on the configuration inputs holding steady from a frame's start until its verdict is registered. They also rely on a new frame start never landing on the edge just after the sixth byte is taken, so there is at least one cycle between the last address byte and the next start. The bench changes configuration only while no frame is in progress. Its random frames insert gaps of zero or more idle cycles between bytes, and it always ends a frame with at least two idle cycles. Random frames mix exact, broadcast, group and arbitrary addresses, and the configuration is redrawn on every frame.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
    localparam int ADDR_BYTES   = 6;
    localparam int ADDR_W       = 8 * ADDR_BYTES;
    localparam int HASH_BITS    = 6;
    localparam int HASH_ENTRIES = 1 << HASH_BITS;
    localparam int CRC_W        = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef struct packed {
        logic bcast;
        logic group;
        logic hash_hit;
        logic perfect_hit;
        logic verdict;
    } filt_status_t;

    typedef struct packed {
        logic promisc;
        logic pass_all;
        logic pass_all_mcast;
        logic inverse;
        logic bcast_reject;
    } filt_mode_t;

    function automatic logic [CRC_W-1:0] crc_take_byte(input logic [CRC_W-1:0] c_in,
                                                       input logic [7:0] b);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ b[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction
endpackage

// File: rtl/eaf_addr_capture.sv
module eaf_addr_capture
    import eaf_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  da_start,
    input  logic                  da_valid,
    input  logic [7:0]            da_byte,
    output logic                  byte_take,
    output logic                  frame_start,
    output logic                  frame_done,
    output logic [8*NBYTES-1:0]   addr
);
    localparam int CW = $clog2(NBYTES + 1);
    localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);
    localparam logic [CW-1:0] FULL = CW'(NBYTES);

    logic [CW-1:0] cnt;
    logic          mid_frame;

    assign frame_start = da_valid && da_start;
    assign mid_frame   = (cnt != '0) && (cnt < FULL);
    assign byte_take   = frame_start || (da_valid && mid_frame);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            frame_done <= 1'b0;
            addr       <= '0;
        end else begin
            frame_done <= 1'b0;
            if (frame_start) begin
                addr[7:0] <= da_byte;
                cnt       <= CW'(1);
            end else if (da_valid && mid_frame) begin
                addr[int'(cnt)*8 +: 8] <= da_byte;
                cnt                    <= cnt + CW'(1);
                if (cnt == LAST) frame_done <= 1'b1;
            end
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

// File: rtl/eaf_hash_unit.sv
module eaf_hash_unit
    import eaf_pkg::*;
#(
    parameter int IDX_W = HASH_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             byte_take,
    input  logic [7:0]       da_byte,
    output logic [IDX_W-1:0] hash_idx
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    assign crc_base = frame_start ? CRC_SEED : crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (byte_take) begin
            crc_q <= crc_take_byte(crc_base, da_byte);
        end
    end

    assign hash_idx = crc_q[CRC_W-1 -: IDX_W];
endmodule

// File: rtl/eaf_decide.sv
module eaf_decide
    import eaf_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int IDX_W = HASH_BITS,
    localparam int NBIN = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             frame_done,
    input  logic [AW-1:0]    addr,
    input  logic [IDX_W-1:0] hash_idx,
    input  logic [AW-1:0]    station,
    input  logic [NBIN-1:0]  hash_table,
    input  filt_mode_t       mode,
    output logic             result_valid,
    output logic             accept,
    output filt_status_t     status
);
    filt_status_t st_next;
    logic         acc_next;

    always_comb begin
        st_next             = '0;
        st_next.group       = addr[0];
        st_next.bcast       = &addr;
        st_next.perfect_hit = (addr == station);
        st_next.hash_hit    = addr[0] && hash_table[hash_idx];
        if (st_next.bcast) begin
            st_next.verdict = !mode.bcast_reject;
        end else if (st_next.group) begin
            st_next.verdict = mode.pass_all_mcast || st_next.hash_hit;
        end else begin
            st_next.verdict = st_next.perfect_hit ^ mode.inverse;
        end
        acc_next = st_next.verdict || mode.promisc || mode.pass_all;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid <= 1'b0;
            accept       <= 1'b0;
            status       <= '0;
        end else if (frame_done) begin
            result_valid <= 1'b1;
            accept       <= acc_next;
            status       <= st_next;
        end else if (frame_start) begin
            result_valid <= 1'b0;
            accept       <= 1'b0;
            status       <= '0;
        end
    end

    assert_done_gives_result_R2: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> result_valid);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start && !frame_done |=> !result_valid);
    assert_result_held_R2: assert property (@(posedge clk) disable iff (rst)
        result_valid && !frame_start && !frame_done |=> $stable(accept) && $stable(status));
    assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done && mode.promisc |=> accept);
    assert_pass_all_accepts_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done && mode.pass_all |=> accept);
    assert_bcast_is_group_R9: assert property (@(posedge clk) disable iff (rst)
        result_valid && status.bcast |-> status.group);
    assert_hash_only_group_R4: assert property (@(posedge clk) disable iff (rst)
        result_valid && status.hash_hit |-> status.group);
endmodule

// File: rtl/eaf_rx_filter.sv
module eaf_rx_filter
    import eaf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    da_start,
    input  logic                    da_valid,
    input  logic [7:0]              da_byte,
    input  logic [ADDR_W-1:0]       cfg_station_addr,
    input  logic [HASH_ENTRIES-1:0] cfg_hash_table,
    input  logic                    cfg_promisc,
    input  logic                    cfg_pass_all,
    input  logic                    cfg_pass_all_mcast,
    input  logic                    cfg_inverse,
    input  logic                    cfg_bcast_reject,
    output logic                    result_valid,
    output logic                    accept,
    output logic [4:0]              filt_status
);
    logic              byte_take;
    logic              frame_start;
    logic              frame_done;
    logic [ADDR_W-1:0] addr;
    logic [HASH_BITS-1:0] hash_idx;
    filt_mode_t        mode;
    filt_status_t      status;

    assign mode.promisc        = cfg_promisc;
    assign mode.pass_all       = cfg_pass_all;
    assign mode.pass_all_mcast = cfg_pass_all_mcast;
    assign mode.inverse        = cfg_inverse;
    assign mode.bcast_reject   = cfg_bcast_reject;

    eaf_addr_capture #(.NBYTES(ADDR_BYTES)) u_capture (
        .clk(clk), .rst(rst), .da_start(da_start), .da_valid(da_valid),
        .da_byte(da_byte), .byte_take(byte_take), .frame_start(frame_start),
        .frame_done(frame_done), .addr(addr)
    );

    eaf_hash_unit #(.IDX_W(HASH_BITS)) u_hash (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_take(byte_take),
        .da_byte(da_byte), .hash_idx(hash_idx)
    );

    eaf_decide #(.AW(ADDR_W), .IDX_W(HASH_BITS)) u_decide (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_done(frame_done),
        .addr(addr), .hash_idx(hash_idx), .station(cfg_station_addr),
        .hash_table(cfg_hash_table), .mode(mode), .result_valid(result_valid),
        .accept(accept), .status(status)
    );

    assign filt_status = status;
endmodule

// File: tb/eaf_rx_filter_tb.sv
`timescale 1ns/1ps
module eaf_rx_filter_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        da_start, da_valid;
    logic [7:0]  da_byte;
    logic [47:0] station;
    logic [63:0] htab;
    logic        promisc, pass_all, pass_mc, inverse, bc_rej;
    logic        result_valid, accept;
    logic [4:0]  filt_status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    eaf_rx_filter u_dut (
        .clk(clk), .rst(rst), .da_start(da_start), .da_valid(da_valid), .da_byte(da_byte),
        .cfg_station_addr(station), .cfg_hash_table(htab), .cfg_promisc(promisc),
        .cfg_pass_all(pass_all), .cfg_pass_all_mcast(pass_mc), .cfg_inverse(inverse),
        .cfg_bcast_reject(bc_rej), .result_valid(result_valid), .accept(accept),
        .filt_status(filt_status)
    );

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic f = r[31] ^ a[i];
            r = {r[30:0], 1'b0};
            if (f) r = r ^ 32'h04C11DB7;
        end
        return r[31:26];
    endfunction

    // returns {accept, status[4:0]}
    function automatic logic [5:0] model(input logic [47:0] a);
        logic grp = a[0];
        logic bc  = (a == 48'hFFFF_FFFF_FFFF);
        logic ph  = (a == station);
        logic hh  = grp && htab[hidx(a)];
        logic v;
        if (bc) v = !bc_rej;
        else if (grp) v = pass_mc || hh;
        else v = ph ^ inverse;
        return {v | promisc | pass_all, bc, grp, hh, ph, v};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic send(input logic [47:0] a, input int gapmax, input int extra);
        for (int i = 0; i < 6 + extra; i++) begin
            if (i > 0 && gapmax > 0) begin
                repeat ($urandom % (gapmax + 1)) begin
                    @(negedge clk); da_valid = 0; da_start = 0;
                end
            end
            @(negedge clk);
            da_valid = 1;
            da_start = (i == 0);
            da_byte  = (i < 6) ? a[i*8 +: 8] : 8'($urandom);
        end
        @(negedge clk); da_valid = 0; da_start = 0;
        @(negedge clk);
    endtask

    task automatic frame_chk(input string req, input logic [47:0] a, input int gapmax, input int extra);
        logic [5:0] e;
        e = model(a);
        send(a, gapmax, extra);
        check(req, {25'd0, result_valid, accept, filt_status}, {25'd0, 1'b1, e});
    endtask

    task automatic modes(input logic p, input logic pa, input logic pm, input logic iv, input logic br);
        promisc = p; pass_all = pa; pass_mc = pm; inverse = iv; bc_rej = br;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [47:0] a, mc;
        logic [5:0]  ix;
        void'($urandom(32'd4242));
        rst = 1; da_start = 0; da_valid = 0; da_byte = 0;
        station = 48'h5544_3322_1102; htab = '0;
        modes(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R1 result_valid", {31'd0, result_valid}, 0);
        check("R1 accept", {31'd0, accept}, 0);
        check("R1 status", {27'd0, filt_status}, 0);
        rst = 0;

        // R3 exact and inverse
        frame_chk("R3 exact match", station, 0, 0);
        check("R3 accept set", {31'd0, accept}, 1);
        frame_chk("R3 mismatch", 48'h5544_3322_1104, 0, 0);
        check("R3 mismatch dropped", {31'd0, accept}, 0);
        modes(0, 0, 0, 1, 0);
        frame_chk("R3 inverse match", station, 0, 0);
        check("R3 inverse drops station", {31'd0, accept}, 0);
        frame_chk("R3 inverse other", 48'h0000_0000_0010, 0, 0);
        check("R3 inverse keeps other", {31'd0, accept}, 1);

        // R6 broadcast, R7 promiscuous
        modes(0, 0, 0, 0, 0);
        frame_chk("R6 broadcast kept", '1, 0, 0);
        modes(0, 0, 0, 0, 1);
        frame_chk("R6 broadcast rejected", '1, 0, 0);
        check("R6 rejected accept", {31'd0, accept}, 0);
        modes(1, 0, 0, 0, 1);
        frame_chk("R7 promisc over bcast reject", '1, 0, 0);
        check("R7 accept", {31'd0, accept}, 1);

        // R4 hash hit and miss
        modes(0, 0, 0, 0, 0);
        mc = 48'h0000_5E00_0001;
        ix = hidx(mc);
        htab = 64'd1 << ix;
        frame_chk("R4 hash hit", mc, 1, 0);
        check("R4 hit accept", {31'd0, accept}, 1);
        htab = ~(64'd1 << ix);
        frame_chk("R4 hash miss", mc, 1, 0);
        check("R4 miss accept", {31'd0, accept}, 0);
        // R5 pass-all-multicast
        modes(0, 0, 1, 0, 0);
        frame_chk("R5 pass all multicast", mc, 0, 0);
        check("R5 accept", {31'd0, accept}, 1);

        // R8 pass-all keeps verdict 0 in status
        modes(0, 1, 0, 0, 0);
        frame_chk("R8 pass all mismatch", 48'h1111_2222_3334, 0, 0);
        check("R8 verdict bit", {31'd0, filt_status[0]}, 0);
        check("R8 accept", {31'd0, accept}, 1);

        // R2 extra bytes ignored, start clears
        modes(0, 0, 0, 0, 0);
        frame_chk("R2 trailing bytes ignored", station, 2, 5);
        @(negedge clk); da_valid = 1; da_byte = 8'hAB; da_start = 0;
        @(negedge clk); da_valid = 0;
        check("R2 stray byte ignored", {30'd0, result_valid, accept}, 2'b11);
        @(negedge clk); da_valid = 1; da_start = 1; da_byte = station[7:0];
        @(negedge clk); da_valid = 0; da_start = 0;
        check("R2 start clears result", {30'd0, result_valid, accept}, 0);
        send(station, 0, 0);

        // R9 random frames with random modes
        for (int k = 0; k < 400; k++) begin
            int sel = $urandom % 5;
            htab = {$urandom, $urandom};
            modes(($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
                  ($urandom % 4) == 0, ($urandom % 2) == 0);
            case (sel)
                0: a = station;
                1: a = '1;
                2: a = {$urandom, 16'($urandom)} | 48'd1;
                default: a = {$urandom, 16'($urandom)};
            endcase
            frame_chk("R9 random frame", a, 3, $urandom % 3);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule